// File: doc/BRIEF.md
# Dual-Host Shared GPIO Controller

This block is a bank of general-purpose pins shared by two processors. Each processor has its own register bank: output value, direction, input readback, interrupt level, interrupt flags and interrupt enable. A per-pin owner register decides which bank drives each pin's output value and direction. A per-pin output mask, set to all ones at reset, can force any pin's driver off no matter what the owning bank asks for.

Pin inputs pass through a two-flop synchronizer. Both banks read the same synchronized value. Each bank raises level-sensitive interrupt flags only for the pins it owns, and drives its own registered interrupt line. Only the primary bank can write the owner and mask registers. The secondary bank reads zero in those two slots.

Top module: `shared_gpio_ctrl`

## Requirements
- R1: Register indexes, the same in both banks: 0 output value, 1 direction, 2 synchronized input (read-only), 3 interrupt level, 4 interrupt flags, 5 interrupt enable, 6 owner, 7 output mask. The read data is registered and shows the register selected by the address in the previous cycle.
- R2: Writing a 1 to a bit of the flag register (index 4) clears that flag. Writing a 0 leaves it unchanged.
- R3: When a pin's owner bit is 1, the secondary bank's output register drives `pin_o`. When it is 0, the primary bank's output register drives it. `pin_o` is registered, one cycle after the registers.
- R4: `pin_oe` for a pin is the owning bank's direction bit (1 = output) ANDed with the mask bit. It is registered, one cycle after the registers.
- R5: A flag bit becomes 1 at every clock edge where the pin is owned by that bank and the synchronized input equals the level bit. When a clearing write and the set condition occur in the same cycle, the set wins.
- R6: Only the primary bank can write owner and mask. Secondary writes to indexes 6 and 7 are ignored, and secondary reads of those indexes return 0.
- R7: Each bank's interrupt output is 1 in the cycle after the OR of (flag AND enable) over its pins was 1.
- R8: A bank's flag bits for pins it does not own are 0.
- R9: The mask resets to ones on all NPINS pins. Data bits at and above NPINS are fixed: they read 0 from every register and ignore writes.
- R10: The input register shows `pin_i` two clock edges late. Both banks read the same value whatever the ownership.
- R11: At reset, all bank registers, the owner register, `pin_o`, `pin_oe`, both interrupt outputs and the read data are 0. The mask is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p_wr | input | 1 | Primary bank write strobe |
| p_addr | input | 3 | Primary bank register index |
| p_wdata | input | DW | Primary bank write data |
| p_rdata | output | DW | Primary bank registered read data |
| s_wr | input | 1 | Secondary bank write strobe |
| s_addr | input | 3 | Secondary bank register index |
| s_wdata | input | DW | Secondary bank write data |
| s_rdata | output | DW | Secondary bank registered read data |
| pin_i | input | NPINS | Asynchronous pin inputs |
| pin_o | output | NPINS | Pad output values |
| pin_oe | output | NPINS | Pad output enables |
| irq_p | output | 1 | Primary bank interrupt |
| irq_s | output | 1 | Secondary bank interrupt |

## Verification
The assertions check four things on every cycle:
- No pad is enabled against a cleared mask bit.
- No bank holds a flag for a pin it did not own.
- Each interrupt line follows its bank's enabled flags one cycle late.
- Secondary-only writes leave the owner and mask unchanged, and the upper read-data bits stay zero.

Only the bench's scenarios can show:
- The write-one-to-clear behaviour, and that a set wins over a clear in the same cycle.
- The owner-based routing of pin values.
- The two-edge input latency.
- The exact register readback values.

These come from a cycle model compared against the design, and from directed sequences with hand-computed values.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    REG_OUT  = 3'd0,
    REG_DIR  = 3'd1,
    REG_IN   = 3'd2,
    REG_LVL  = 3'd3,
    REG_FLAG = 3'd4,
    REG_IEN  = 3'd5,
    REG_OWN  = 3'd6,
    REG_MASK = 3'd7
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int NPINS   = 24,
  parameter int DW      = 32,
  parameter bit PRIMARY = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [DW-1:0]    wdata,
  input  logic [NPINS-1:0] sync_in,
  input  logic [NPINS-1:0] own,
  input  logic [NPINS-1:0] ctl_owner,
  input  logic [NPINS-1:0] ctl_mask,
  output logic [NPINS-1:0] out_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] flag_q,
  output logic [NPINS-1:0] ien_q,
  output logic [DW-1:0]    rdata,
  output logic             irq
);
  localparam int PAD = DW - NPINS;

  logic [NPINS-1:0] lvl_q;
  logic [NPINS-1:0] clr;
  logic [NPINS-1:0] hit;
  logic [NPINS-1:0] rd_own, rd_mask;
  logic [NPINS-1:0] rd_sel;
  gpio_reg_e        sel;

  assign sel = gpio_reg_e'(addr);

  generate
    if (PRIMARY) begin : g_ctl_rd
      assign rd_own  = ctl_owner;
      assign rd_mask = ctl_mask;
    end else begin : g_ctl_hidden
      assign rd_own  = '0;
      assign rd_mask = '0;
    end
  endgenerate

  assign clr = (wr && sel == REG_FLAG) ? wdata[NPINS-1:0] : '0;
  assign hit = own & ~(sync_in ^ lvl_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      lvl_q  <= '0;
      ien_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr) begin
        case (sel)
          REG_OUT: out_q <= wdata[NPINS-1:0];
          REG_DIR: dir_q <= wdata[NPINS-1:0];
          REG_LVL: lvl_q <= wdata[NPINS-1:0];
          REG_IEN: ien_q <= wdata[NPINS-1:0];
          default: ;
        endcase
      end
      flag_q <= ((flag_q & ~clr) | hit) & own;
    end
  end

  always_comb begin
    case (sel)
      REG_OUT:  rd_sel = out_q;
      REG_DIR:  rd_sel = dir_q;
      REG_IN:   rd_sel = sync_in;
      REG_LVL:  rd_sel = lvl_q;
      REG_FLAG: rd_sel = flag_q;
      REG_IEN:  rd_sel = ien_q;
      REG_OWN:  rd_sel = rd_own;
      default:  rd_sel = rd_mask;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      rdata <= {{PAD{1'b0}}, rd_sel};
      irq   <= |(flag_q & ien_q);
    end
  end
endmodule

// File: rtl/gpio_route.sv
module gpio_route
  import gpio_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [DW-1:0]    wdata,
  input  logic [NPINS-1:0] p_out,
  input  logic [NPINS-1:0] p_dir,
  input  logic [NPINS-1:0] s_out,
  input  logic [NPINS-1:0] s_dir,
  output logic [NPINS-1:0] owner_q,
  output logic [NPINS-1:0] mask_q,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= '0;
      mask_q  <= '1;
      pin_o   <= '0;
      pin_oe  <= '0;
    end else begin
      if (wr && gpio_reg_e'(addr) == REG_OWN)  owner_q <= wdata[NPINS-1:0];
      if (wr && gpio_reg_e'(addr) == REG_MASK) mask_q  <= wdata[NPINS-1:0];
      pin_o  <= (p_out & ~owner_q) | (s_out & owner_q);
      pin_oe <= ((p_dir & ~owner_q) | (s_dir & owner_q)) & mask_q;
    end
  end
endmodule

// File: rtl/shared_gpio_ctrl.sv
module shared_gpio_ctrl #(
  parameter int NPINS = 24,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             p_wr,
  input  logic [2:0]       p_addr,
  input  logic [DW-1:0]    p_wdata,
  output logic [DW-1:0]    p_rdata,
  input  logic             s_wr,
  input  logic [2:0]       s_addr,
  input  logic [DW-1:0]    s_wdata,
  output logic [DW-1:0]    s_rdata,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq_p,
  output logic             irq_s
);
  logic [NPINS-1:0] sync_in;
  logic [NPINS-1:0] owner_q, mask_q;
  logic [NPINS-1:0] p_out, p_dir, p_flag, p_ien;
  logic [NPINS-1:0] s_out, s_dir, s_flag, s_ien;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .d(pin_i), .q(sync_in)
  );

  gpio_bank #(.NPINS(NPINS), .DW(DW), .PRIMARY(1'b1)) u_pbank (
    .clk(clk), .rst(rst), .wr(p_wr), .addr(p_addr), .wdata(p_wdata),
    .sync_in(sync_in), .own(~owner_q), .ctl_owner(owner_q), .ctl_mask(mask_q),
    .out_q(p_out), .dir_q(p_dir), .flag_q(p_flag), .ien_q(p_ien),
    .rdata(p_rdata), .irq(irq_p)
  );

  gpio_bank #(.NPINS(NPINS), .DW(DW), .PRIMARY(1'b0)) u_sbank (
    .clk(clk), .rst(rst), .wr(s_wr), .addr(s_addr), .wdata(s_wdata),
    .sync_in(sync_in), .own(owner_q), .ctl_owner(owner_q), .ctl_mask(mask_q),
    .out_q(s_out), .dir_q(s_dir), .flag_q(s_flag), .ien_q(s_ien),
    .rdata(s_rdata), .irq(irq_s)
  );

  gpio_route #(.NPINS(NPINS), .DW(DW)) u_route (
    .clk(clk), .rst(rst), .wr(p_wr), .addr(p_addr), .wdata(p_wdata),
    .p_out(p_out), .p_dir(p_dir), .s_out(s_out), .s_dir(s_dir),
    .owner_q(owner_q), .mask_q(mask_q), .pin_o(pin_o), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/gpio_ctrl_checker.sv
module gpio_ctrl_checker #(
  parameter int NPINS = 24,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             p_wr,
  input logic             s_wr,
  input logic [NPINS-1:0] owner_q,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] p_flag,
  input logic [NPINS-1:0] p_ien,
  input logic [NPINS-1:0] s_flag,
  input logic [NPINS-1:0] s_ien,
  input logic [NPINS-1:0] pin_oe,
  input logic [DW-1:0]    p_rdata,
  input logic [DW-1:0]    s_rdata,
  input logic             irq_p,
  input logic             irq_s
);
  localparam logic [DW-1:0] PIN_MASK = {{(DW-NPINS){1'b0}}, {NPINS{1'b1}}};

  assert_oe_masked_R4: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & ~$past(mask_q)) == '0);

  assert_pflag_owned_R8: assert property (@(posedge clk) disable iff (rst)
    (p_flag & $past(owner_q)) == '0);

  assert_sflag_owned_R8: assert property (@(posedge clk) disable iff (rst)
    (s_flag & ~$past(owner_q)) == '0);

  assert_irq_p_R7: assert property (@(posedge clk) disable iff (rst)
    irq_p == $past(|(p_flag & p_ien)));

  assert_irq_s_R7: assert property (@(posedge clk) disable iff (rst)
    irq_s == $past(|(s_flag & s_ien)));

  assert_sec_no_ctl_write_R6: assert property (@(posedge clk) disable iff (rst)
    (s_wr && !p_wr) |=> ($stable(owner_q) && $stable(mask_q)));

  assert_upper_bits_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ((p_rdata & ~PIN_MASK) == '0) && ((s_rdata & ~PIN_MASK) == '0));
endmodule

bind shared_gpio_ctrl gpio_ctrl_checker #(.NPINS(NPINS), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .p_wr(p_wr), .s_wr(s_wr),
  .owner_q(owner_q), .mask_q(mask_q),
  .p_flag(p_flag), .p_ien(p_ien), .s_flag(s_flag), .s_ien(s_ien),
  .pin_oe(pin_oe), .p_rdata(p_rdata), .s_rdata(s_rdata),
  .irq_p(irq_p), .irq_s(irq_s)
);

// File: tb/tb_shared_gpio_ctrl.sv
module tb_shared_gpio_ctrl;
  localparam int NPINS = 24;
  localparam int DW    = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic p_wr = 1'b0, s_wr = 1'b0;
  logic [2:0] p_addr = '0, s_addr = '0;
  logic [DW-1:0] p_wdata = '0, s_wdata = '0;
  logic [DW-1:0] p_rdata, s_rdata;
  logic [NPINS-1:0] pin_i = '0;
  logic [NPINS-1:0] pin_o, pin_oe;
  logic irq_p, irq_s;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_gpio_ctrl #(.NPINS(NPINS), .DW(DW)) dut (.*);

  // behavioural reference model
  logic [23:0] m_s1, m_s2, m_own, m_mask;
  logic [23:0] m_pout, m_pdir, m_plvl, m_pflag, m_pien;
  logic [23:0] m_sout, m_sdir, m_slvl, m_sflag, m_sien;
  logic [31:0] m_prd, m_srd;
  logic [23:0] m_po, m_poe;
  logic m_irqp, m_irqs;

  function automatic logic [31:0] m_read(bit prim, logic [2:0] a);
    logic [23:0] v;
    case (a)
      3'd0: v = prim ? m_pout  : m_sout;
      3'd1: v = prim ? m_pdir  : m_sdir;
      3'd2: v = m_s2;
      3'd3: v = prim ? m_plvl  : m_slvl;
      3'd4: v = prim ? m_pflag : m_sflag;
      3'd5: v = prim ? m_pien  : m_sien;
      3'd6: v = prim ? m_own   : 24'h0;
      default: v = prim ? m_mask : 24'h0;
    endcase
    return {8'h00, v};
  endfunction

  always @(posedge clk) begin
    logic [23:0] pclr, sclr, npf, nsf;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_own = 0; m_mask = 24'hFFFFFF;
      m_pout = 0; m_pdir = 0; m_plvl = 0; m_pflag = 0; m_pien = 0;
      m_sout = 0; m_sdir = 0; m_slvl = 0; m_sflag = 0; m_sien = 0;
      m_prd = 0; m_srd = 0; m_po = 0; m_poe = 0; m_irqp = 0; m_irqs = 0;
    end else begin
      m_prd  = m_read(1'b1, p_addr);
      m_srd  = m_read(1'b0, s_addr);
      m_irqp = |(m_pflag & m_pien);
      m_irqs = |(m_sflag & m_sien);
      m_po   = (m_pout & ~m_own) | (m_sout & m_own);
      m_poe  = ((m_pdir & ~m_own) | (m_sdir & m_own)) & m_mask;
      pclr = (p_wr && p_addr == 3'd4) ? p_wdata[23:0] : 24'h0;
      sclr = (s_wr && s_addr == 3'd4) ? s_wdata[23:0] : 24'h0;
      npf = ((m_pflag & ~pclr) | (~m_own & ~(m_s2 ^ m_plvl))) & ~m_own;
      nsf = ((m_sflag & ~sclr) | (m_own & ~(m_s2 ^ m_slvl))) & m_own;
      m_pflag = npf;
      m_sflag = nsf;
      if (p_wr) begin
        case (p_addr)
          3'd0: m_pout = p_wdata[23:0];
          3'd1: m_pdir = p_wdata[23:0];
          3'd3: m_plvl = p_wdata[23:0];
          3'd5: m_pien = p_wdata[23:0];
          3'd6: m_own  = p_wdata[23:0];
          3'd7: m_mask = p_wdata[23:0];
          default: ;
        endcase
      end
      if (s_wr) begin
        case (s_addr)
          3'd0: m_sout = s_wdata[23:0];
          3'd1: m_sdir = s_wdata[23:0];
          3'd3: m_slvl = s_wdata[23:0];
          3'd5: m_sien = s_wdata[23:0];
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pin_i;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R1 p_rdata model", p_rdata, m_prd);
      check("R1 s_rdata model", s_rdata, m_srd);
      check("R3 pin_o model", {8'h0, pin_o}, {8'h0, m_po});
      check("R4 pin_oe model", {8'h0, pin_oe}, {8'h0, m_poe});
      check("R7 irq_p model", {31'h0, irq_p}, {31'h0, m_irqp});
      check("R7 irq_s model", {31'h0, irq_s}, {31'h0, m_irqs});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic wr_p(logic [2:0] a, logic [31:0] d);
    @(negedge clk); p_wr = 1; p_addr = a; p_wdata = d;
    @(negedge clk); p_wr = 0;
  endtask

  task automatic wr_s(logic [2:0] a, logic [31:0] d);
    @(negedge clk); s_wr = 1; s_addr = a; s_wdata = d;
    @(negedge clk); s_wr = 0;
  endtask

  task automatic rd_p(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); p_addr = a;
    @(negedge clk); v = p_rdata;
  endtask

  task automatic rd_s(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); s_addr = a;
    @(negedge clk); v = s_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    idle(3);
    // R11: reset state
    check("R11 pin_o at reset", {8'h0, pin_o}, 32'h0);
    check("R11 pin_oe at reset", {8'h0, pin_oe}, 32'h0);
    check("R11 irq at reset", {30'h0, irq_p, irq_s}, 32'h0);
    check("R11 rdata at reset", p_rdata | s_rdata, 32'h0);
    rst = 0;
    cmp_on = 1;
    idle(4);

    // R5: level 0 matches low inputs on all primary-owned pins
    rd_p(3'd4, v); check("R5 flags set on level match", v, 32'h00FFFFFF);
    rd_s(3'd4, v); check("R8 secondary owns nothing", v, 32'h0);

    // R2: write-one-to-clear, zero leaves unchanged
    wr_p(3'd3, 32'h00FFFFFF);
    wr_p(3'd4, 32'h000000FF);
    rd_p(3'd4, v); check("R2 w1c clears ones", v, 32'h00FFFF00);
    wr_p(3'd4, 32'h0);
    rd_p(3'd4, v); check("R2 zero write keeps flags", v, 32'h00FFFF00);

    // R5: set wins over clear
    wr_p(3'd3, 32'h0);
    wr_p(3'd4, 32'h00FFFFFF);
    rd_p(3'd4, v); check("R5 set beats clear", v, 32'h00FFFFFF);

    // R9: mask reset and fixed upper bits
    rd_p(3'd7, v); check("R9 mask reset", v, 32'h00FFFFFF);
    wr_p(3'd7, 32'hFFFFFFFF);
    rd_p(3'd7, v); check("R9 mask upper bits fixed", v, 32'h00FFFFFF);

    // R6: secondary cannot write or see owner/mask
    wr_s(3'd6, 32'h00FFFFFF);
    wr_s(3'd7, 32'h0);
    rd_p(3'd6, v); check("R6 owner unchanged by secondary", v, 32'h0);
    rd_p(3'd7, v); check("R6 mask unchanged by secondary", v, 32'h00FFFFFF);
    rd_s(3'd6, v); check("R6 secondary owner read", v, 32'h0);
    rd_s(3'd7, v); check("R6 secondary mask read", v, 32'h0);

    // R3 / R4: routing and masking
    wr_p(3'd1, 32'h00FFFFFF);
    wr_p(3'd0, 32'h00123456);
    idle(2);
    check("R3 primary drives pin_o", {8'h0, pin_o}, 32'h00123456);
    check("R4 primary dir enables", {8'h0, pin_oe}, 32'h00FFFFFF);
    wr_p(3'd7, 32'h00FF00FF);
    idle(2);
    check("R4 mask gates pin_oe", {8'h0, pin_oe}, 32'h00FF00FF);
    wr_s(3'd0, 32'h00ABCDEF);
    wr_s(3'd1, 32'h0000000F);
    wr_p(3'd6, 32'h000000FF);
    idle(2);
    check("R3 owner split pin_o", {8'h0, pin_o}, 32'h001234EF);
    check("R4 owner split pin_oe", {8'h0, pin_oe}, 32'h00FF000F);

    // R8: flags follow ownership
    idle(2);
    rd_p(3'd4, v); check("R8 primary unowned flags zero", v, 32'h00FFFF00);
    rd_s(3'd4, v); check("R8 secondary owned flags", v, 32'h000000FF);

    // R7: interrupt from enabled flag
    wr_s(3'd5, 32'h00000001);
    idle(2);
    check("R7 irq_s asserted", {31'h0, irq_s}, 32'h1);
    check("R7 irq_p idle", {31'h0, irq_p}, 32'h0);

    // R10: synchronized input shared by both banks
    @(negedge clk); pin_i = 24'h00A5A5;
    idle(3);
    rd_s(3'd2, v); check("R10 secondary input read", v, 32'h0000A5A5);
    rd_p(3'd2, v); check("R10 primary input read", v, 32'h0000A5A5);

    // random traffic compared against the model every cycle (R1..R10)
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      p_wr = ($urandom_range(0, 3) == 0);
      p_addr = 3'($urandom_range(0, 7));
      p_wdata = $urandom;
      s_wr = ($urandom_range(0, 3) == 0);
      s_addr = 3'($urandom_range(0, 7));
      s_wdata = $urandom;
      if ($urandom_range(0, 4) == 0) pin_i = 24'($urandom);
    end
    @(negedge clk); p_wr = 0; s_wr = 0;
    idle(3);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule